// File: doc/BRIEF.md
# Toggle-on-write interrupt status aggregator

This block gathers single-cycle event pulses from a serial-peripheral data path into a sticky interrupt status register. The pending bits are qualified by a per-bit enable register and a single master enable bit. The result drives one registered, level-sensitive interrupt line. Software reaches the three registers over a simple 32-bit single-cycle access port.

Two behaviours set it apart from a plain clear-on-write status register. First, a write to the status register flips every selected bit instead of clearing it, so the same write can clear one bit and set another. Second, on every register access, whatever the address or direction, the current receive-FIFO levels (not empty, full) are ORed into their status bits. Clearing one of those bits while its condition still holds therefore has no lasting effect. Pulse events always win over a flip in the same cycle.

Top module: `irq_status_agg`

## Requirements
- R1: After reset the master enable, status and enable registers all read 0 and `irq` is low.
- R2: A write to the status register (byte offset 0x20) XORs the write data into the defined status bits 2, 3, 4, 5, 6 and 8 (mask 0x17C). All other status bits always read 0.
- R3: The event pulses set sticky status bits: transmit byte sets bit 2 (transmit empty) and bit 8 (receive not empty), overrun sets bit 5, underrun sets bit 3, transmit half empty sets bit 6, receive full sets bit 4. Without a status write, a set bit stays set.
- R4: Every access, read or write, to any address ORs `lvl_rx_nonempty` into bit 8 and `lvl_rx_full` into bit 4, after any flip. The read data returns the value from before that access.
- R5: When an event pulse and a status write hit the same bit in the same cycle, the bit ends up set.
- R6: `irq` equals (any bit of status AND enable is set) AND master enable. It updates on the clock edge that commits the access or event causing the change.
- R7: The master enable register (0x1C) stores only bit 31, and other bits read 0. The enable register (0x28) stores and reads back all 32 bits.
- R8: A write to an unmapped offset changes no register, and a read of an unmapped offset returns 0.
- R9: Without an access, the level inputs do not change the status register or `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, pre-access value |
| evt_tx_byte | input | 1 | Pulse: one byte shifted out |
| evt_rx_overrun | input | 1 | Pulse: receive data dropped |
| evt_tx_underrun | input | 1 | Pulse: transmit ran dry |
| evt_tx_half | input | 1 | Pulse: transmit FIFO half empty |
| evt_rx_full | input | 1 | Pulse: receive FIFO became full |
| lvl_rx_nonempty | input | 1 | Level: receive FIFO holds data |
| lvl_rx_full | input | 1 | Level: receive FIFO is full |
| irq | output | 1 | Registered level interrupt |

## Verification
A status flip and an event pulse can land on the same bit in the same cycle. The bench provokes this by asserting the overrun and underrun pulses on the same clock as a status write that toggles those bits. It then reads the register back and expects the bits set. A second pairing puts the access-time level merge together with a flip that tries to clear bit 8 or bit 4 while the FIFO level is still high. The bits must survive, and `irq` must hold.

// File: rtl/irq_status_agg_pkg.sv
package irq_status_agg_pkg;
  localparam int DATA_W = 32;

  localparam int B_TX_EMPTY  = 2;
  localparam int B_TX_UNDER  = 3;
  localparam int B_RX_FULL   = 4;
  localparam int B_RX_OVR    = 5;
  localparam int B_TX_HALF   = 6;
  localparam int B_RX_NEMPTY = 8;
  localparam int B_MASTER_EN = 31;

  localparam logic [7:0] OFF_MASTER = 8'h1C;
  localparam logic [7:0] OFF_STATUS = 8'h20;
  localparam logic [7:0] OFF_ENABLE = 8'h28;

  typedef struct packed {
    logic tx_byte;
    logic rx_overrun;
    logic tx_underrun;
    logic tx_half;
    logic rx_full;
  } evt_t;

  function automatic logic [DATA_W-1:0] status_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    m[B_TX_EMPTY]  = 1'b1;
    m[B_TX_UNDER]  = 1'b1;
    m[B_RX_FULL]   = 1'b1;
    m[B_RX_OVR]    = 1'b1;
    m[B_TX_HALF]   = 1'b1;
    m[B_RX_NEMPTY] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_status_agg_decode.sv
module irq_status_agg_decode
  import irq_status_agg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  output logic              access,
  output logic              sel_master,
  output logic              sel_status,
  output logic              sel_enable,
  output logic              wr_master,
  output logic              wr_status,
  output logic              wr_enable
);
  always_comb begin
    access     = valid;
    sel_master = valid && (addr == ADDR_W'(OFF_MASTER));
    sel_status = valid && (addr == ADDR_W'(OFF_STATUS));
    sel_enable = valid && (addr == ADDR_W'(OFF_ENABLE));
    wr_master  = sel_master && write;
    wr_status  = sel_status && write;
    wr_enable  = sel_enable && write;
  end
endmodule

// File: rtl/irq_status_agg_status.sv
module irq_status_agg_status
  import irq_status_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flip_we,
  input  logic [DATA_W-1:0] flip_data,
  input  evt_t              evt,
  input  logic              access,
  input  logic              lvl_nonempty,
  input  logic              lvl_full,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] stat_d
);
  localparam logic [DATA_W-1:0] MASK = status_mask();

  logic [DATA_W-1:0] set_v;
  logic [DATA_W-1:0] flipped;
  logic              stat_en;

  always_comb begin
    set_v = '0;
    set_v[B_TX_EMPTY]  = evt.tx_byte;
    set_v[B_RX_NEMPTY] = evt.tx_byte | (access & lvl_nonempty);
    set_v[B_RX_OVR]    = evt.rx_overrun;
    set_v[B_TX_UNDER]  = evt.tx_underrun;
    set_v[B_TX_HALF]   = evt.tx_half;
    set_v[B_RX_FULL]   = evt.rx_full | (access & lvl_full);
    flipped = flip_we ? (stat_q ^ flip_data) : stat_q;
    stat_d  = (flipped | set_v) & MASK;
    stat_en = flip_we | (|set_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end
endmodule

// File: rtl/irq_status_agg_cfg.sv
module irq_status_agg_cfg
  import irq_status_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_master,
  input  logic              wr_enable,
  input  logic [DATA_W-1:0] wdata,
  output logic              master_q,
  output logic              master_d,
  output logic [DATA_W-1:0] enable_q,
  output logic [DATA_W-1:0] enable_d
);
  always_comb begin
    master_d = wr_master ? wdata[B_MASTER_EN] : master_q;
    enable_d = wr_enable ? wdata : enable_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
    end else if (wr_master) begin
      master_q <= master_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
    end else if (wr_enable) begin
      enable_q <= enable_d;
    end
  end
endmodule

// File: rtl/irq_status_agg_line.sv
module irq_status_agg_line
  import irq_status_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] stat_d,
  input  logic [DATA_W-1:0] enable_d,
  input  logic              master_d,
  output logic              irq_q
);
  logic irq_d;

  always_comb begin
    irq_d = master_d & (|(stat_d & enable_d));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_status_agg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              evt_tx_byte,
  input  logic              evt_rx_overrun,
  input  logic              evt_tx_underrun,
  input  logic              evt_tx_half,
  input  logic              evt_rx_full,
  input  logic              lvl_rx_nonempty,
  input  logic              lvl_rx_full,
  output logic              irq
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  logic access, sel_master, sel_status, sel_enable;
  logic wr_master, wr_status, wr_enable;
  evt_t evt;

  assign evt = '{tx_byte: evt_tx_byte, rx_overrun: evt_rx_overrun,
                 tx_underrun: evt_tx_underrun, tx_half: evt_tx_half,
                 rx_full: evt_rx_full};

  irq_status_agg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .valid(bus_valid), .write(bus_write), .addr(bus_addr),
    .access(access), .sel_master(sel_master), .sel_status(sel_status),
    .sel_enable(sel_enable), .wr_master(wr_master), .wr_status(wr_status),
    .wr_enable(wr_enable)
  );

  logic [DATA_W-1:0] stat_q, stat_d, enable_q, enable_d;
  logic              master_q, master_d;

  irq_status_agg_status u_stat (
    .clk(clk), .rst_n(rst_sync_n), .flip_we(wr_status), .flip_data(bus_wdata),
    .evt(evt), .access(access), .lvl_nonempty(lvl_rx_nonempty),
    .lvl_full(lvl_rx_full), .stat_q(stat_q), .stat_d(stat_d)
  );

  irq_status_agg_cfg u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .wr_master(wr_master), .wr_enable(wr_enable),
    .wdata(bus_wdata), .master_q(master_q), .master_d(master_d),
    .enable_q(enable_q), .enable_d(enable_d)
  );

  irq_status_agg_line u_line (
    .clk(clk), .rst_n(rst_sync_n), .stat_d(stat_d), .enable_d(enable_d),
    .master_d(master_d), .irq_q(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (!bus_write) begin
      if (sel_master) bus_rdata[B_MASTER_EN] = master_q;
      if (sel_status) bus_rdata = stat_q;
      if (sel_enable) bus_rdata = enable_q;
    end
  end
endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk
  import irq_status_agg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              evt_rx_overrun,
  input logic              evt_tx_byte,
  input logic              evt_tx_underrun,
  input logic              evt_tx_half,
  input logic              evt_rx_full,
  input logic              lvl_rx_nonempty,
  input logic [DATA_W-1:0] stat_q,
  input logic [DATA_W-1:0] enable_q,
  input logic              master_q,
  input logic              irq
);
  localparam logic [DATA_W-1:0] MASK = status_mask();
  logic stat_wr;
  logic any_evt;
  assign stat_wr = bus_valid && bus_write && (bus_addr == ADDR_W'(OFF_STATUS));
  assign any_evt = evt_rx_overrun | evt_tx_byte | evt_tx_underrun | evt_tx_half | evt_rx_full;

  assert_undef_zero_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stat_q & ~MASK) == '0);

  assert_overrun_sets_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    evt_rx_overrun |=> stat_q[B_RX_OVR]);

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !stat_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_level_merge_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_valid && lvl_rx_nonempty) |=> stat_q[B_RX_NEMPTY]);

  assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stat_wr && evt_tx_underrun) |=> stat_q[B_TX_UNDER]);

  assert_irq_level_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq == (master_q && (|(stat_q & enable_q))));

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!bus_valid && !any_evt) |=> $stable(stat_q));
endmodule

bind irq_status_agg irq_status_agg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .bus_valid(bus_valid),
  .bus_write(bus_write), .bus_addr(bus_addr), .evt_rx_overrun(evt_rx_overrun),
  .evt_tx_byte(evt_tx_byte), .evt_tx_underrun(evt_tx_underrun),
  .evt_tx_half(evt_tx_half), .evt_rx_full(evt_rx_full),
  .lvl_rx_nonempty(lvl_rx_nonempty), .stat_q(stat_q), .enable_q(enable_q),
  .master_q(master_q), .irq(irq)
);

// File: tb/irq_status_agg_test.sv
module irq_status_agg_test;
  localparam int ADDR_W = 8;
  localparam logic [31:0] MASK = 32'h0000_017C;

  logic clk, rst_n;
  logic bus_valid, bus_write;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic evt_tx_byte, evt_rx_overrun, evt_tx_underrun, evt_tx_half, evt_rx_full;
  logic lvl_rx_nonempty, lvl_rx_full;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [31:0] model;
  logic [31:0] rd;

  irq_status_agg #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_tx_byte(evt_tx_byte), .evt_rx_overrun(evt_rx_overrun),
    .evt_tx_underrun(evt_tx_underrun), .evt_tx_half(evt_tx_half),
    .evt_rx_full(evt_rx_full), .lvl_rx_nonempty(lvl_rx_nonempty),
    .lvl_rx_full(lvl_rx_full), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // evs: [0] tx_byte [1] rx_overrun [2] tx_underrun [3] tx_half [4] rx_full
  task automatic cyc(input logic v, input logic w, input logic [7:0] a,
                     input logic [31:0] d, input logic [4:0] evs,
                     output logic [31:0] r);
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
    {evt_rx_full, evt_tx_half, evt_tx_underrun, evt_rx_overrun, evt_tx_byte} = evs;
    #1 r = bus_rdata;
    @(posedge clk);
    #1;
    bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    {evt_rx_full, evt_tx_half, evt_tx_underrun, evt_rx_overrun, evt_tx_byte} = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    cyc(1'b1, 1'b1, a, d, 5'b0, dummy);
  endtask

  task automatic rdr(input logic [7:0] a, output logic [31:0] r);
    cyc(1'b1, 1'b0, a, '0, 5'b0, r);
  endtask

  function automatic logic [31:0] pat_to_bits(input int p);
    logic [31:0] v;
    v = '0;
    v[2] = p[0]; v[3] = p[1]; v[4] = p[2];
    v[5] = p[3]; v[6] = p[4]; v[8] = p[5];
    return v;
  endfunction

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] dummy;
    rst_n = 1'b0;
    bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0;
    evt_tx_byte = 0; evt_rx_overrun = 0; evt_tx_underrun = 0;
    evt_tx_half = 0; evt_rx_full = 0; lvl_rx_nonempty = 0; lvl_rx_full = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rdr(8'h1C, rd); chk("R1 master", rd, 32'h0);
    rdr(8'h20, rd); chk("R1 status", rd, 32'h0);
    rdr(8'h28, rd); chk("R1 enable", rd, 32'h0);

    // R7 register widths
    wr(8'h1C, 32'hFFFF_FFFF);
    rdr(8'h1C, rd); chk("R7 master bit31 only", rd, 32'h8000_0000);
    wr(8'h28, 32'hA5A5_1234);
    rdr(8'h28, rd); chk("R7 enable full width", rd, 32'hA5A5_1234);

    // R2 / R6 sweep: enable bits 2,4,6,8 with master on
    wr(8'h28, 32'h0000_0154);
    model = '0;
    wr(8'h20, 32'hFFFF_FFFF); model ^= MASK;
    chk("R6 irq after flip", {31'b0, irq}, {31'b0, |(model & 32'h154)});
    rdr(8'h20, rd); chk("R2 flip all", rd, model);
    for (int p = 0; p < 64; p++) begin
      wr(8'h20, pat_to_bits(p) | 32'hF0F0_0A81);
      model ^= pat_to_bits(p);
      chk("R6 irq sweep", {31'b0, irq}, {31'b0, |(model & 32'h154)});
      rdr(8'h20, rd); chk("R2 flip sweep", rd, model);
    end

    // R6 master enable gates the line
    wr(8'h20, model ^ 32'h0000_0004); model = 32'h4;
    chk("R6 irq set", {31'b0, irq}, 32'h1);
    wr(8'h1C, 32'h7FFF_FFFF);
    chk("R6 master off", {31'b0, irq}, 32'h0);
    wr(8'h1C, 32'h8000_0000);
    chk("R6 master on", {31'b0, irq}, 32'h1);
    wr(8'h20, 32'h4); model = '0;
    chk("R6 cleared", {31'b0, irq}, 32'h0);

    // R3 each event alone
    cyc(1'b0, 1'b0, 8'h00, '0, 5'b00001, dummy);
    rdr(8'h20, rd); chk("R3 tx_byte", rd, 32'h104); wr(8'h20, 32'h104);
    cyc(1'b0, 1'b0, 8'h00, '0, 5'b00010, dummy);
    rdr(8'h20, rd); chk("R3 overrun", rd, 32'h020); wr(8'h20, 32'h020);
    cyc(1'b0, 1'b0, 8'h00, '0, 5'b00100, dummy);
    rdr(8'h20, rd); chk("R3 underrun", rd, 32'h008); wr(8'h20, 32'h008);
    cyc(1'b0, 1'b0, 8'h00, '0, 5'b01000, dummy);
    repeat (3) cyc(1'b0, 1'b0, 8'h00, '0, 5'b0, dummy);
    rdr(8'h20, rd); chk("R3 half sticky", rd, 32'h040); wr(8'h20, 32'h040);
    cyc(1'b0, 1'b0, 8'h00, '0, 5'b10000, dummy);
    rdr(8'h20, rd); chk("R3 rx_full", rd, 32'h010); wr(8'h20, 32'h010);

    // R9 levels ignored while idle; enable only bit 8
    wr(8'h28, 32'h0000_0100);
    lvl_rx_nonempty = 1'b1;
    repeat (4) cyc(1'b0, 1'b0, 8'h00, '0, 5'b0, dummy);
    chk("R9 idle irq", {31'b0, irq}, 32'h0);
    // R4 any access merges; read returns pre-access value
    rdr(8'h30, rd); chk("R8 unmapped read", rd, 32'h0);
    chk("R4 irq after access", {31'b0, irq}, 32'h1);
    rdr(8'h20, rd); chk("R4 merged bit8", rd, 32'h100);
    wr(8'h20, 32'h100);
    rdr(8'h20, rd); chk("R4 flip cannot clear", rd, 32'h100);
    chk("R4 irq held", {31'b0, irq}, 32'h1);
    lvl_rx_nonempty = 1'b0; lvl_rx_full = 1'b1;
    wr(8'h20, 32'h100);
    rdr(8'h20, rd); chk("R4 rx_full level", rd, 32'h010);
    lvl_rx_full = 1'b0;
    wr(8'h20, 32'h010);
    rdr(8'h20, rd); chk("R4 cleared", rd, 32'h0);

    // R5 event and flip on same bits same cycle
    wr(8'h20, 32'h020);
    cyc(1'b1, 1'b1, 8'h20, 32'h028, 5'b00110, dummy);
    rdr(8'h20, rd); chk("R5 event wins", rd, 32'h028);

    // R8 unmapped write
    wr(8'h24, 32'hFFFF_FFFF);
    rdr(8'h20, rd); chk("R8 status kept", rd, 32'h028);
    rdr(8'h28, rd); chk("R8 enable kept", rd, 32'h100);
    rdr(8'h1C, rd); chk("R8 master kept", rd, 32'h8000_0000);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule